// File: doc/BRIEF.md
# Four-Channel Byte DMA Engine

This block moves bytes across a simple system bus so the CPU does not have to. It has four channels. Each channel holds a 16-bit current address, a 16-bit current count and a base copy of both. A peripheral raises its request line, the engine asks the CPU for the bus, and once the CPU hands the bus over it runs byte cycles. In each cycle the engine drives the memory address and the read and write strobes, and answers the peripheral with an acknowledge. Memory-to-memory copies are also supported. In that mode each byte is first read into an internal holding register and then written out.

The CPU programs the engine through an 8-bit register port. Each 16-bit value goes in as two bytes, low byte first. An internal byte pointer tracks which byte is next. Per-channel mode bits set the transfer direction, auto-reload, the address step direction and single or block operation. A transfer ends on count exhaustion or on an external end input. Every address stays inside a 64 KiB window.

Top module: `quad_dma`

## Requirements
- R1: After reset all request masks are set. The bus request, every strobe, every acknowledge and the end output are low. All channel registers read back as zero. Requests on any channel start nothing until that channel is unmasked.
- R2: Register offsets 0 to 7 select channel n's address at 2n and count at 2n+1. Reads and writes of these offsets use the byte pointer: low byte first, then high. Each access toggles the pointer, and any write to offset 11 resets it to the low byte. A write updates both the base and the current copy; a read returns the current copy.
- R3: No strobe and no acknowledge is driven unless both bus request and bus grant are high. The bus request falls only after a cycle that drove a memory strobe.
- R4: Unmasked requests are served by fixed priority, channel 0 highest. A masked channel is never acknowledged. Offset 9 writes the whole mask from data bits [3:0].
- R5: Offset 8 writes a channel's mode: bits [1:0] select the channel, bit 2 selects device-to-memory, bit 3 auto-reload, bit 4 address decrement and bit 5 single mode. In single mode one byte moves per granted request and the bus request is then released.
- R6: The count decrements once per byte. The byte in which the count steps from 0 to 0xFFFF is the last one, so a count of N moves N+1 bytes. The end output is high during that last byte only. In block mode the bus is held from the first byte to the last.
- R7: After each byte the address steps by +1, or by -1 when the decrement bit is set.
- R8: At the end of a transfer on a channel with auto-reload, the current address and count reload from the base copy and the mask stays clear. Without auto-reload, the channel's mask bit is set.
- R9: When the external end input is high during a byte cycle, that byte is the last one. The channel then finishes exactly as at terminal count.
- R10: When bit 0 of offset 10 is set, an unmasked channel 0 request starts a memory-to-memory copy. Each byte is read from channel 0's address into a holding register and then written to channel 1's address. The copy ends when channel 1's count is exhausted.
- R11: The address wraps from 0xFFFF to 0x0000 and never carries past 16 bits.
- R12: A device-to-memory byte drives the I/O read and memory write strobes. A memory-to-device byte drives the memory read and I/O write strobes. Read and write strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 4 | Register offset for CPU accesses |
| reg_wdata | input | 8 | CPU write data |
| reg_we | input | 1 | CPU write strobe |
| reg_re | input | 1 | CPU read strobe |
| reg_rdata | output | 8 | CPU read data |
| drq | input | 4 | Per-channel transfer requests |
| dack | output | 4 | Per-channel acknowledges |
| hold_req | output | 1 | Bus request to the CPU |
| hold_ack | input | 1 | Bus grant from the CPU |
| eop_in | input | 1 | External end-of-transfer |
| eop_out | output | 1 | High during the last byte of a transfer |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Device read strobe |
| io_wr | output | 1 | Device write strobe |
| data_in | input | 8 | Memory read data for copies |
| data_out | output | 8 | Holding register contents written during copies |

## Verification
The bench checks the off-by-one count: a count of N must move N+1 bytes. A design that stops at count zero would move one byte too few and raise the end output a byte early. Two more checks cover the end of a transfer. Auto-reload must restore the base values and leave the channel armed, while a plain channel must mask itself; a wrong design would either run away on a held request or lose the programmed values. The bench also stops a block transfer with the external end input, runs an address across 0xFFFF and runs a memory copy. These catch an early-stop signal that is ignored, a carry past 16 bits, and a copy that steps on the wrong channel's count.

// File: rtl/quad_dma.sv
module quad_dma #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int DW  = 8,
  localparam int CW = $clog2(NCH),
  localparam int RW = $clog2(2*NCH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          reg_we,
  input  logic          reg_re,
  output logic [DW-1:0] reg_rdata,
  input  logic [NCH-1:0] drq,
  output logic [NCH-1:0] dack,
  output logic          hold_req,
  input  logic          hold_ack,
  input  logic          eop_in,
  output logic          eop_out,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          io_rd,
  output logic          io_wr,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out
);

  typedef enum logic [2:0] {S_IDLE, S_HOLD, S_XFER, S_MRD, S_MWR} st_t;

  st_t st;
  logic [AW-1:0] base_a [NCH];
  logic [AW-1:0] base_c [NCH];
  logic [AW-1:0] cur_a  [NCH];
  logic [AW-1:0] cur_c  [NCH];
  logic [NCH-1:0] m_tomem, m_auto, m_down, m_single, mask;
  logic m2m_en, ptr, mm, any_req;
  logic [CW-1:0] ch, pick;
  logic [DW-1:0] tmp;

  wire [NCH-1:0] req = drq & ~mask;

  always_comb begin
    pick = '0;
    any_req = 1'b0;
    for (int i = NCH-1; i >= 0; i--)
      if (req[i]) begin
        pick = CW'(i);
        any_req = 1'b1;
      end
  end

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a, input logic dn);
    return dn ? a - AW'(1) : a + AW'(1);
  endfunction

  wire xfer  = (st == S_XFER);
  wire rd_ph = (st == S_MRD);
  wire wr_ph = (st == S_MWR);
  wire last  = (cur_c[ch] == '0);
  wire last1 = (cur_c[1] == '0);
  wire fin   = eop_in | last;
  wire fin1  = eop_in | last1;

  wire          cpu_chreg = (reg_addr < RW'(2*NCH));
  wire [CW-1:0] rsel      = reg_addr[CW:1];
  wire [AW-1:0] rval      = reg_addr[0] ? cur_c[rsel] : cur_a[rsel];

  assign reg_rdata = cpu_chreg ? (ptr ? rval[AW-1:DW] : rval[DW-1:0]) : '0;
  assign hold_req  = (st != S_IDLE);
  assign dack      = xfer ? (NCH'(1) << ch) : '0;
  assign mem_rd    = (xfer & ~m_tomem[ch]) | rd_ph;
  assign mem_wr    = (xfer &  m_tomem[ch]) | wr_ph;
  assign io_rd     = xfer &  m_tomem[ch];
  assign io_wr     = xfer & ~m_tomem[ch];
  assign eop_out   = (xfer & last) | (wr_ph & last1);
  assign mem_addr  = rd_ph ? cur_a[0] : wr_ph ? cur_a[1] : xfer ? cur_a[ch] : '0;
  assign data_out  = tmp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      mask <= '1;
      m2m_en <= 1'b0;
      ptr <= 1'b0;
      ch <= '0;
      mm <= 1'b0;
      tmp <= '0;
      m_tomem <= '0;
      m_auto <= '0;
      m_down <= '0;
      m_single <= '0;
      for (int i = 0; i < NCH; i++) begin
        base_a[i] <= '0;
        base_c[i] <= '0;
        cur_a[i]  <= '0;
        cur_c[i]  <= '0;
      end
    end else begin
      if (reg_we) begin
        if (cpu_chreg) begin
          if (reg_addr[0]) begin
            if (ptr) begin
              base_c[rsel][AW-1:DW] <= reg_wdata;
              cur_c[rsel][AW-1:DW]  <= reg_wdata;
            end else begin
              base_c[rsel][DW-1:0] <= reg_wdata;
              cur_c[rsel][DW-1:0]  <= reg_wdata;
            end
          end else begin
            if (ptr) begin
              base_a[rsel][AW-1:DW] <= reg_wdata;
              cur_a[rsel][AW-1:DW]  <= reg_wdata;
            end else begin
              base_a[rsel][DW-1:0] <= reg_wdata;
              cur_a[rsel][DW-1:0]  <= reg_wdata;
            end
          end
          ptr <= ~ptr;
        end else if (reg_addr == RW'(2*NCH)) begin
          m_tomem[reg_wdata[CW-1:0]]  <= reg_wdata[CW];
          m_auto[reg_wdata[CW-1:0]]   <= reg_wdata[CW+1];
          m_down[reg_wdata[CW-1:0]]   <= reg_wdata[CW+2];
          m_single[reg_wdata[CW-1:0]] <= reg_wdata[CW+3];
        end else if (reg_addr == RW'(2*NCH+1)) begin
          mask <= reg_wdata[NCH-1:0];
        end else if (reg_addr == RW'(2*NCH+2)) begin
          m2m_en <= reg_wdata[0];
        end else if (reg_addr == RW'(2*NCH+3)) begin
          ptr <= 1'b0;
        end
      end else if (reg_re && cpu_chreg) begin
        ptr <= ~ptr;
      end

      case (st)
        S_IDLE:
          if (any_req) begin
            ch <= pick;
            mm <= m2m_en && (pick == '0);
            st <= S_HOLD;
          end
        S_HOLD:
          if (hold_ack) st <= mm ? S_MRD : S_XFER;
        S_XFER: begin
          if (fin && m_auto[ch]) begin
            cur_a[ch] <= base_a[ch];
            cur_c[ch] <= base_c[ch];
          end else begin
            cur_a[ch] <= step(cur_a[ch], m_down[ch]);
            cur_c[ch] <= cur_c[ch] - AW'(1);
          end
          if (fin && !m_auto[ch]) mask[ch] <= 1'b1;
          if (fin || m_single[ch]) st <= S_IDLE;
        end
        S_MRD: begin
          tmp <= data_in;
          st <= S_MWR;
        end
        S_MWR: begin
          if (fin1 && m_auto[0]) cur_a[0] <= base_a[0];
          else                   cur_a[0] <= step(cur_a[0], m_down[0]);
          if (fin1 && m_auto[1]) begin
            cur_a[1] <= base_a[1];
            cur_c[1] <= base_c[1];
          end else begin
            cur_a[1] <= step(cur_a[1], m_down[1]);
            cur_c[1] <= cur_c[1] - AW'(1);
          end
          if (fin1) begin
            if (!m_auto[0]) mask[0] <= 1'b1;
            st <= S_IDLE;
          end else begin
            st <= S_MRD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/quad_dma_chk.sv
module quad_dma_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hold_req,
  input logic           hold_ack,
  input logic [NCH-1:0] dack,
  input logic           mem_rd,
  input logic           mem_wr,
  input logic           io_rd,
  input logic           io_wr,
  input logic           eop_out
);

  AST_BUS_ONLY_WHEN_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr || io_rd || io_wr || dack != '0) |-> (hold_req && hold_ack)); // R3
  AST_RELEASE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_req) |-> $past(mem_rd || mem_wr)); // R3
  AST_SINGLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack)); // R4
  AST_EOP_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    eop_out |-> (mem_rd || mem_wr)); // R6
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr) && !(io_rd && io_wr)); // R12
  AST_ACK_HAS_IO: assert property (@(posedge clk) disable iff (!rst_n)
    (dack != '0) |-> (io_rd ^ io_wr)); // R12

endmodule

bind quad_dma quad_dma_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .hold_ack(hold_ack),
  .dack(dack), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd),
  .io_wr(io_wr), .eop_out(eop_out)
);

// File: tb/tb_quad_dma.sv
`timescale 1ns/1ps
module tb_quad_dma;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0] reg_rdata;
  logic [3:0] drq = '0;
  logic [3:0] dack;
  logic hold_req, hold_ack, eop_in = 1'b0, eop_out;
  logic [15:0] mem_addr;
  logic mem_rd, mem_wr, io_rd, io_wr;
  logic [7:0] data_in, data_out;

  quad_dma dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata), .drq(drq),
    .dack(dack), .hold_req(hold_req), .hold_ack(hold_ack), .eop_in(eop_in),
    .eop_out(eop_out), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .io_rd(io_rd), .io_wr(io_wr), .data_in(data_in), .data_out(data_out)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, nbytes = 0, rel = 0;
  bit done = 1'b0;
  logic hold_q = 1'b0;
  logic [15:0] alog [16];
  logic        elog [16];
  logic [3:0]  dlog [16];
  logic [7:0]  mem [256];
  logic [7:0]  io_byte = 8'hA5;

  always @(posedge clk) hold_ack <= rst_n ? hold_req : 1'b0;
  always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= io_rd ? io_byte : data_out;
  assign data_in = mem[mem_addr[7:0]];

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd || mem_wr) begin
        alog[nbytes[3:0]] = mem_addr;
        elog[nbytes[3:0]] = eop_out;
        dlog[nbytes[3:0]] = {mem_rd, mem_wr, io_rd, io_wr};
        nbytes++;
      end
      if (hold_q && !hold_req) rel++;
      hold_q = hold_req;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_re = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_re = 1'b0;
  endtask

  task automatic prog16(input logic [3:0] off, input logic [15:0] v);
    wr(4'd11, 8'h00); wr(off, v[7:0]); wr(off, v[15:8]);
  endtask

  task automatic rd16(input logic [3:0] off, output logic [15:0] v);
    logic [7:0] lo, hi;
    wr(4'd11, 8'h00); rd(off, lo); rd(off, hi);
    v = {hi, lo};
  endtask

  task automatic setmode(input logic [1:0] c, input bit tomem, input bit au,
                         input bit dn, input bit sg);
    wr(4'd8, {2'b00, sg, dn, au, tomem, c});
  endtask

  task automatic wait_dack(input int c, output bit ok);
    ok = 1'b0;
    for (int n = 0; n < 50 && !ok; n++) begin
      tick();
      if (dack[c]) ok = 1'b1;
    end
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 100 && hold_req; n++) tick();
    tick(); tick();
  endtask

  task automatic t_reset();
    logic [15:0] v;
    tick();
    chk("R1 hold_req", hold_req, 0);
    chk("R1 strobes", {mem_rd, mem_wr, io_rd, io_wr, eop_out}, 0);
    chk("R1 dack", dack, 0);
    drq = 4'hF;
    repeat (10) tick();
    chk("R1 masked at reset", {29'd0, nbytes[0], hold_req, rel[0]}, 0);
    drq = 4'h0;
    rd16(4'd0, v);
    chk("R1 regs zero", v, 16'h0000);
  endtask

  task automatic t_ptr();
    logic [15:0] v;
    prog16(4'd0, 16'h1234);
    rd16(4'd0, v);
    chk("R2 low then high", v, 16'h1234);
    wr(4'd11, 8'h00); wr(4'd1, 8'hAA);
    wr(4'd11, 8'h00); wr(4'd1, 8'h78); wr(4'd1, 8'h56);
    rd16(4'd1, v);
    chk("R2 pointer clear", v, 16'h5678);
  endtask

  task automatic t_single();
    logic [15:0] v;
    bit ok;
    int r0;
    prog16(4'd4, 16'h0040); prog16(4'd5, 16'h0002);
    setmode(2'd2, 1'b1, 1'b0, 1'b0, 1'b1);
    wr(4'd9, 8'h0B);
    nbytes = 0; r0 = rel;
    for (int i = 0; i < 3; i++) begin
      drq[2] = 1'b1;
      wait_dack(2, ok);
      drq[2] = 1'b0;
      chk("R5 ack seen", ok, 1);
      repeat (5) tick();
      chk("R5 bus released", hold_req, 0);
    end
    chk("R5 one byte per request", nbytes, 3);
    chk("R5 releases", rel - r0, 3);
    chk("R7 increment addr", {alog[0], alog[2]}, {16'h0040, 16'h0042});
    chk("R6 eop last only", {elog[0], elog[1], elog[2]}, 3'b001);
    chk("R12 device to memory strobes", dlog[0], 4'b0110);
    chk("R12 byte stored", mem[8'h41], 8'hA5);
    rd16(4'd4, v); chk("R7 final addr", v, 16'h0043);
    rd16(4'd5, v); chk("R6 count wrapped", v, 16'hFFFF);
    drq[2] = 1'b1;
    repeat (20) tick();
    drq[2] = 1'b0;
    chk("R8 masked after end", nbytes, 3);
  endtask

  task automatic t_priority();
    bit ok;
    prog16(4'd2, 16'h0100); prog16(4'd3, 16'h0010);
    prog16(4'd6, 16'h0200); prog16(4'd7, 16'h0010);
    setmode(2'd1, 1'b1, 1'b0, 1'b0, 1'b1);
    setmode(2'd3, 1'b1, 1'b0, 1'b0, 1'b1);
    wr(4'd9, 8'h05);
    drq = 4'b1010;
    ok = 1'b0;
    for (int n = 0; n < 50 && !ok; n++) begin tick(); if (dack != 0) ok = 1'b1; end
    chk("R4 channel 1 wins", dack, 4'b0010);
    drq = 4'b0000;
    wait_idle();
    wr(4'd9, 8'h07);
    drq = 4'b1010;
    ok = 1'b0;
    for (int n = 0; n < 50 && !ok; n++) begin tick(); if (dack != 0) ok = 1'b1; end
    chk("R4 masked channel skipped", dack, 4'b1000);
    drq = 4'b0000;
    wait_idle();
  endtask

  task automatic t_block();
    bit ok;
    int r0;
    prog16(4'd6, 16'h0010); prog16(4'd7, 16'h0003);
    setmode(2'd3, 1'b0, 1'b0, 1'b1, 1'b0);
    wr(4'd9, 8'h07);
    nbytes = 0; r0 = rel;
    drq[3] = 1'b1;
    wait_dack(3, ok);
    drq[3] = 1'b0;
    wait_idle();
    chk("R6 N plus one bytes", nbytes, 4);
    chk("R6 bus held", rel - r0, 1);
    chk("R7 decrement", {alog[0], alog[1], alog[2], alog[3]},
        {16'h0010, 16'h000F, 16'h000E, 16'h000D});
    chk("R6 eop on last", {elog[0], elog[1], elog[2], elog[3]}, 4'b0001);
    chk("R12 memory to device strobes", dlog[0], 4'b1001);
  endtask

  task automatic t_auto();
    logic [15:0] v;
    bit ok;
    prog16(4'd2, 16'h0080); prog16(4'd3, 16'h0001);
    setmode(2'd1, 1'b1, 1'b1, 1'b0, 1'b0);
    wr(4'd9, 8'h0D);
    nbytes = 0;
    drq[1] = 1'b1; wait_dack(1, ok); drq[1] = 1'b0;
    wait_idle();
    chk("R8 bytes before reload", nbytes, 2);
    rd16(4'd2, v); chk("R8 addr reloaded", v, 16'h0080);
    rd16(4'd3, v); chk("R8 count reloaded", v, 16'h0001);
    drq[1] = 1'b1; wait_dack(1, ok); drq[1] = 1'b0;
    chk("R8 still armed", ok, 1);
    wait_idle();
  endtask

  task automatic t_eop();
    logic [15:0] v;
    bit ok;
    prog16(4'd0, 16'h0020); prog16(4'd1, 16'h0009);
    setmode(2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    wr(4'd9, 8'h0E);
    nbytes = 0;
    drq[0] = 1'b1; wait_dack(0, ok); drq[0] = 1'b0;
    for (int n = 0; n < 50 && hold_req; n++) begin
      if (nbytes == 3) eop_in = 1'b1;
      tick();
    end
    eop_in = 1'b0;
    wait_idle();
    chk("R9 early stop", nbytes, 3);
    rd16(4'd0, v); chk("R9 addr", v, 16'h0023);
    rd16(4'd1, v); chk("R9 count", v, 16'h0006);
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    bit ok;
    prog16(4'd4, 16'hFFFE); prog16(4'd5, 16'h0002);
    setmode(2'd2, 1'b1, 1'b0, 1'b0, 1'b0);
    wr(4'd9, 8'h0B);
    nbytes = 0;
    drq[2] = 1'b1; wait_dack(2, ok); drq[2] = 1'b0;
    wait_idle();
    chk("R11 wrap sequence", {alog[0], alog[1], alog[2]},
        {16'hFFFE, 16'hFFFF, 16'h0000});
    rd16(4'd4, v); chk("R11 final addr", v, 16'h0001);
  endtask

  task automatic t_m2m();
    logic [15:0] v;
    mem[8'h50] = 8'h11; mem[8'h51] = 8'h22; mem[8'h52] = 8'h33;
    mem[8'h63] = 8'h77;
    prog16(4'd0, 16'h0050); prog16(4'd1, 16'h0010);
    prog16(4'd2, 16'h0060); prog16(4'd3, 16'h0002);
    setmode(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    setmode(2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    wr(4'd10, 8'h01);
    wr(4'd9, 8'h0C);
    drq[0] = 1'b1;
    for (int n = 0; n < 50 && !hold_req; n++) tick();
    drq[0] = 1'b0;
    wait_idle();
    chk("R10 copied", {mem[8'h60], mem[8'h61], mem[8'h62]}, 24'h112233);
    chk("R10 stops at count", mem[8'h63], 8'h77);
    rd16(4'd3, v); chk("R10 dest count", v, 16'hFFFF);
    rd16(4'd0, v); chk("R10 source addr", v, 16'h0053);
    wr(4'd10, 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ptr();
    t_single();
    t_priority();
    t_block();
    t_auto();
    t_eop();
    t_wrap();
    t_m2m();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule